// File: doc/BRIEF.md
# Free-Address Return Switch (2x2)

This block is one switching element of a banyan-style network that carries the addresses of free heap cells from memory banks back toward the processors that allocate them. Each of its two upstream ports offers one 24-bit free-cell address at a time under a valid/ready handshake. Each of its two downstream ports presents a buffered address under the same handshake. Between them sits a small FIFO per downstream port that acts as the switch's holding area.

Traffic normally flows straight across, from upstream port i to downstream port i, which keeps an address close to the bank it came from. When a downstream port runs low on addresses and its own straight input has nothing to offer, that port may also take an address from the crossed input. This spreads heavy allocation demand across banks. Whenever a downstream port hands out an address, its FIFO gains room, so the switch asks its inputs for a replacement in the next cycle.

Top module: `freeaddr_switch2x2`

## Requirements
- R1: After a synchronous active-low reset, both downstream valid flags are low and both upstream ready flags are high.
- R2: An address accepted on upstream port i while downstream FIFO i holds fewer than 4 entries is queued on downstream port i (port 0 to port 0, port 1 to port 1).
- R3: Each downstream port drives valid high whenever its FIFO is non-empty and presents the oldest held address. That address is removed only in a cycle where valid and ready are both high. While ready is low, valid and the address stay unchanged.
- R4: An address offered on upstream port i while FIFO i holds 4 entries goes to the crossed downstream port k if FIFO k holds at most 1 entry and upstream port k has no valid address.
- R5: Upstream ready on port i is low when FIFO i is full and either FIFO k holds 2 or more entries or upstream port k is valid.
- R6: While FIFO i is not full, addresses from upstream port i always go straight to downstream port i, even if the crossed port is hungry.
- R7: Every accepted address appears exactly once, on exactly one downstream port. No address is accepted without room in its target FIFO. Upstream ready on a port does not depend on that port's own valid.
- R8: An address accepted into an empty FIFO at a clock edge is presented on that downstream port directly after that edge.
- R9: When a full FIFO hands out an address at an edge, the matching upstream ready is high directly after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 2 | Upstream address offered, bit i for port i |
| src_ready | output | 2 | Upstream address taken this cycle when valid is also high |
| src_addr | input | 48 | Upstream addresses, port i in bits [24*i+23:24*i] |
| dst_valid | output | 2 | Downstream address available, bit j for port j |
| dst_ready | input | 2 | Downstream consumer takes the presented address |
| dst_addr | output | 48 | Downstream addresses, port j in bits [24*j+23:24*j] |

## Verification
The assertions check on every cycle that:
- no FIFO is pushed when full;
- the number of upstream handshakes equals the number of FIFO pushes;
- a crossed transfer only happens into a hungry port whose straight input is idle;
- the straight path wins whenever it has room;
- a stalled downstream port holds its address;
- a push becomes visible in the next cycle.

Only the bench's scenarios, compared against a queue-based model on every clock, can show the rest:
- end-to-end ordering;
- that each address arrives exactly once on the correct port;
- that ready returns after a full FIFO drains;
- that a busy crossed port blocks the crossing.

// File: rtl/fas_pkg.sv
// Package: shared constants and helpers for the free-address return switch.
// Assumes a fixed two-port switching element; widths are set per instance.
package fas_pkg;

    // Number of ports on each side of the switching element.
    localparam int NPORT = 2;

    // Index of the port diagonally across from port p.
    function automatic int cross_of(input int p);
        return (p == 0) ? 1 : 0;
    endfunction

endpackage

// File: rtl/fas_fifo.sv
// Module: fas_fifo
// Holding buffer for one downstream port. Stores up to DEPTH addresses in
// arrival order, presents the oldest, and dequeues on valid and ready.
// It reports whether it has room and whether it is running low
// (at most LOW_MARK entries).
// Assumes: the producer pushes only when has_space is high; there is no
// pass-through, so a full FIFO takes nothing even in a cycle where it pops.
module fas_fifo #(
    parameter int ADDR_W   = 24,
    parameter int DEPTH    = 4,
    parameter int LOW_MARK = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              has_space,
    output logic              is_low
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              pop;

    // Advance a pointer with wrap at the last slot (any DEPTH).
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign pop       = out_valid & pop_ready;
    assign out_valid = (count != '0);
    assign out_addr  = store[rd_ptr];
    assign has_space = (count < CNT_W'(DEPTH));
    assign is_low    = (count <= CNT_W'(LOW_MARK));

    // Write an incoming address into the tail slot.
    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= push_addr;
        end
    end

    // Move the tail pointer on each push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (push) begin
            wr_ptr <= bump(wr_ptr);
        end
    end

    // Move the head pointer on each handshake at the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (pop) begin
            rd_ptr <= bump(rd_ptr);
        end
    end

    // Track the occupancy from push and pop together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: the router never pushes into a full buffer.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> has_space);

    // R3: a stalled output keeps its address and its valid flag.
    a_r3_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !pop_ready) |=> (out_valid && $stable(out_addr)));

    // R8: a pushed address is visible in the next cycle.
    a_r8_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> out_valid);

endmodule

// File: rtl/fas_route.sv
// Module: fas_route
// Combinational steering for the two upstream ports.
// An upstream address goes straight across when its own downstream buffer
// has room. Otherwise it goes to the crossed buffer, provided that buffer
// is hungry (low and its own straight input is idle) and has room.
// Upstream ready never depends on the same port's valid.
// Assumes: has_space and is_low come from registered buffer state.
module fas_route
    import fas_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] src_valid,
    input  logic [NPORT-1:0] has_space,
    input  logic [NPORT-1:0] is_low,
    output logic [NPORT-1:0] src_ready,
    output logic [NPORT-1:0] push,
    output logic [NPORT-1:0] cross_sel
);

    logic [NPORT-1:0] hungry;
    logic [NPORT-1:0] take_straight;
    logic [NPORT-1:0] take_cross;

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
        localparam int K = cross_of(gi);

        // A buffer is hungry when it is low and its straight input has nothing.
        assign hungry[gi] = is_low[gi] & ~src_valid[gi];

        // Ready: either the straight buffer has room, or the crossed one is hungry with room.
        assign src_ready[gi] = has_space[gi] | (has_space[K] & hungry[K]);

        // The straight path is taken whenever it has room.
        assign take_straight[gi] = src_valid[gi] & has_space[gi];

        // The crossed path is taken only when the straight buffer is full.
        assign take_cross[gi] = src_valid[gi] & ~has_space[gi] & has_space[K] & hungry[K];

        // Buffer gi is fed by its own input, or else by the crossed input.
        assign push[gi]      = take_straight[gi] | take_cross[K];
        assign cross_sel[gi] = take_cross[K];

        // R6: when the straight buffer has room, the crossed path is not used.
        a_r6_straight_first: assert property (@(posedge clk) disable iff (!rst_n)
            (src_valid[gi] && has_space[gi]) |-> !cross_sel[K]);

        // R4: a crossed push lands only in a hungry buffer whose input is idle.
        a_r4_cross_only_hungry: assert property (@(posedge clk) disable iff (!rst_n)
            cross_sel[gi] |-> (!src_valid[gi] && is_low[gi]));
    end

endmodule

// File: rtl/freeaddr_switch2x2.sv
// Module: freeaddr_switch2x2
// Two-by-two switching element that returns free-cell addresses toward the
// processors. It has one holding FIFO per downstream port and a router that
// prefers the straight path and crosses over only for a hungry port.
// Assumes: upstream senders hold valid and address until ready is seen;
// ports are packed as flat vectors, port i in slice [ADDR_W*i +: ADDR_W].
module freeaddr_switch2x2
    import fas_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DEPTH    = 4,
    parameter int LOW_MARK = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        src_valid,
    output logic [NPORT-1:0]        src_ready,
    input  logic [NPORT*ADDR_W-1:0] src_addr,
    output logic [NPORT-1:0]        dst_valid,
    input  logic [NPORT-1:0]        dst_ready,
    output logic [NPORT*ADDR_W-1:0] dst_addr
);

    logic [NPORT-1:0] has_space;
    logic [NPORT-1:0] is_low;
    logic [NPORT-1:0] push;
    logic [NPORT-1:0] cross_sel;

    fas_route u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_valid (src_valid),
        .has_space (has_space),
        .is_low    (is_low),
        .src_ready (src_ready),
        .push      (push),
        .cross_sel (cross_sel)
    );

    for (genvar gj = 0; gj < NPORT; gj++) begin : g_out
        localparam int K = cross_of(gj);
        logic [ADDR_W-1:0] in_addr;

        // Select the straight or crossed upstream address for this buffer.
        assign in_addr = cross_sel[gj] ? src_addr[ADDR_W*K +: ADDR_W]
                                       : src_addr[ADDR_W*gj +: ADDR_W];

        fas_fifo #(
            .ADDR_W   (ADDR_W),
            .DEPTH    (DEPTH),
            .LOW_MARK (LOW_MARK)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push[gj]),
            .push_addr (in_addr),
            .pop_ready (dst_ready[gj]),
            .out_valid (dst_valid[gj]),
            .out_addr  (dst_addr[ADDR_W*gj +: ADDR_W]),
            .has_space (has_space[gj]),
            .is_low    (is_low[gj])
        );
    end

    // R7: each upstream handshake causes exactly one buffer push.
    a_r7_conserve: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_valid & src_ready) == $countones(push));

    // R1: the first cycle after reset shows empty outputs and open inputs.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dst_valid == '0 && src_ready == '1));

endmodule

// File: tb/sim_freeaddr_switch2x2.sv
// Bench: a queue-based reference model, compared at every clock.
module sim_freeaddr_switch2x2;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 24;
    localparam int DEP  = 4;
    localparam int LOWM = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    src_valid = '0;
    logic [1:0]    src_ready;
    logic [2*AW-1:0] src_addr = '0;
    logic [1:0]    dst_valid;
    logic [1:0]    dst_ready = '0;
    logic [2*AW-1:0] dst_addr;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] mq0[$];
    logic [AW-1:0] mq1[$];
    logic [AW-1:0] nxt [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    freeaddr_switch2x2 u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_valid (src_valid),
        .src_ready (src_ready),
        .src_addr  (src_addr),
        .dst_valid (dst_valid),
        .dst_ready (dst_ready),
        .dst_addr  (dst_addr)
    );

    function automatic int msize(input int p);
        return (p == 0) ? mq0.size() : mq1.size();
    endfunction

    function automatic logic [AW-1:0] mhead(input int p);
        return (p == 0) ? mq0[0] : mq1[0];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare against the model, then advance the model at the edge.
    task automatic step(input logic v0, input logic v1, input logic r0,
                        input logic r1, input string tag);
        logic [1:0] v, r, er, acc;
        int sz [2];
        int dest [2];
        @(negedge clk);
        v = {v1, v0};
        r = {r1, r0};
        src_valid = v;
        dst_ready = r;
        src_addr  = {nxt[1], nxt[0]};
        #1;
        for (int i = 0; i < 2; i++) sz[i] = msize(i);
        for (int i = 0; i < 2; i++) begin
            int k = 1 - i;
            er[i] = (sz[i] < DEP) || (sz[k] <= LOWM && !v[k]);
            check(src_ready[i] == er[i], tag, $sformatf("src_ready[%0d]", i),
                  AW'(src_ready[i]), AW'(er[i]));
            check(dst_valid[i] == (sz[i] > 0), tag, $sformatf("dst_valid[%0d]", i),
                  AW'(dst_valid[i]), AW'(sz[i] > 0));
            if (sz[i] > 0)
                check(dst_addr[AW*i +: AW] == mhead(i), tag,
                      $sformatf("dst_addr[%0d]", i), dst_addr[AW*i +: AW], mhead(i));
            acc[i]  = v[i] && er[i];
            dest[i] = (sz[i] < DEP) ? i : k;
        end
        @(posedge clk);
        if (r[0] && sz[0] > 0) void'(mq0.pop_front());
        if (r[1] && sz[1] > 0) void'(mq1.pop_front());
        for (int i = 0; i < 2; i++) begin
            if (acc[i]) begin
                if (dest[i] == 0) mq0.push_back(nxt[i]);
                else              mq1.push_back(nxt[i]);
                nxt[i] = nxt[i] + 1'b1;
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R7 actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        nxt[0] = 24'h100000;
        nxt[1] = 24'h200000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state seen at the ports.
        check(dst_valid == 2'b00, "R1", "dst_valid", AW'(dst_valid), 0);
        check(src_ready == 2'b11, "R1", "src_ready", AW'(src_ready), 3);

        // R8 then R2: both inputs flow straight with outputs open.
        step(1, 1, 1, 1, "R8");
        step(1, 1, 1, 1, "R8");
        for (int n = 0; n < 6; n++) step(1, 1, 1, 1, "R2");

        // R3: stall both outputs while filling, then release.
        for (int n = 0; n < 6; n++) step(1, 1, 0, 0, "R3");
        for (int n = 0; n < 8; n++) step(0, 0, 1, 1, "R3");

        // R4: output 0 stalled and full, input 1 idle, so input 0 crosses to output 1.
        for (int n = 0; n < 10; n++) step(1, 0, 0, 1, "R4");

        // R5: output 1 stalled and input 1 busy, so input 0 must wait.
        for (int n = 0; n < 8; n++) step(1, 1, 0, 0, "R5");

        // R9: output 0 emits one address, and input 0 reopens next cycle.
        step(1, 1, 1, 0, "R9");
        step(1, 1, 0, 0, "R9");
        step(1, 1, 0, 0, "R9");

        // Drain, then R6: room on the straight path beats a hungry crossed port.
        for (int n = 0; n < 8; n++) step(0, 0, 1, 1, "R6");
        for (int n = 0; n < 4; n++) step(1, 0, 0, 1, "R6");

        // R7: a mixed pattern, with all state checked each cycle.
        lf = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], lf[3], lf[5] | lf[7], lf[9] | lf[11], "R7");
        end
        for (int n = 0; n < 12; n++) step(0, 0, 1, 1, "R7");
        @(negedge clk);
        #1;
        check(dst_valid == 2'b00, "R7", "drained dst_valid", AW'(dst_valid), 0);
        check(mq0.size() == 0 && mq1.size() == 0, "R7", "model empty",
              AW'(mq0.size() + mq1.size()), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule